// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block models how a superscalar front end packs instructions into dispatch groups of five slots. The scheduler offers a candidate instruction through the classification inputs. The block then reports on `hazardClass` whether the candidate can join the open group, needs a new group (stall), or needs a no-op placed ahead of it. The report is combinational from the current group state, so the scheduler can query as many candidates as it needs before it commits to one.

Three strobes change the state. `commitStb` records the candidate on the inputs as dispatched. `advanceStb` spends one empty slot. `noopStb` spends one slot on an inserted no-op. The block tracks the number of slots used in the open group and whether a counter-register write has been committed to it. When the group fills, both are cleared. Only one strobe may be raised per cycle. A cycle with more than one strobe raised is rejected and flagged.

Top module: `dispatch_slot_checker`

## Requirements
- R1: After reset `slotCount` is 0 and `seqError` is 0. A fixed-point candidate with no flags reports no hazard.
- R2: A pseudo candidate (`unitClass` 0) reports `hazardClass` 2'b00 whatever its flags and the slot count are. Committing it leaves `slotCount` and the counter-write state unchanged.
- R3: A non-pseudo candidate with `firstOnly` or `singleOnly` set reports 2'b01 (hazard) when `slotCount` is not 0, and reports no slot hazard when `slotCount` is 0.
- R4: A candidate of class fixed-point (1), load/store (2), floating-point (3), vector ALU (4) or vector permute (5) reports 2'b01 when `slotCount` is 4.
- R5: A condition-register candidate (class 6) reports 2'b01 when `slotCount` is 2 or more.
- R6: A branch candidate (class 7) without the first-only or single flags gets no slot hazard at any slot count.
- R7: A candidate with `ctrBranch` set reports 2'b10 (noop hazard) when a commit with `ctrWrite` has already landed in the open group and no slot hazard applies. A slot hazard (2'b01) takes precedence over the noop hazard.
- R8: Committing a non-branch candidate without `singleOnly` increments `slotCount` by one. When the count would reach 5, it returns to 0 and the counter-write state is cleared.
- R9: Committing a branch or a `singleOnly` candidate closes the group at any fill level. `slotCount` becomes 0 and the counter-write state is cleared.
- R10: `advanceStb` and `noopStb` each consume one slot. The count wraps from 4 to 0 and the counter-write state is cleared.
- R11: When more than one strobe is raised in a cycle, `seqError` is 1 in that cycle and the group state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unitClass | input | 3 | Candidate unit: 0 pseudo, 1 fixed, 2 load/store, 3 float, 4 vector ALU, 5 vector permute, 6 condition reg, 7 branch |
| firstOnly | input | 1 | Candidate must lead a group |
| singleOnly | input | 1 | Candidate must lead a group and fills it |
| ctrWrite | input | 1 | Candidate writes the counter register |
| ctrBranch | input | 1 | Candidate branches through the counter register |
| commitStb | input | 1 | Record the candidate as dispatched |
| advanceStb | input | 1 | Spend one empty slot |
| noopStb | input | 1 | Spend one slot on an inserted no-op |
| hazardClass | output | 2 | 00 none, 01 hazard, 10 noop hazard |
| slotCount | output | 3 | Slots used in the open group (0 to 4) |
| seqError | output | 1 | More than one strobe raised this cycle |

## Verification
The properties assume that the classification inputs are stable around each clock edge. They also assume that a strobe describes the candidate currently on those inputs. Most properties also assume a single strobe per cycle. The stimulus changes inputs only on falling edges and raises at most one strobe per vector. It raises two strobes together in exactly one directed step, which tests the rejection path. The counter-branch flag is applied mostly to branch-class candidates. It is also applied to a fixed-point candidate at a full group to confirm that the slot hazard wins.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  typedef enum logic [2:0] {
    UC_PSEUDO = 3'd0,
    UC_FIXED  = 3'd1,
    UC_LDST   = 3'd2,
    UC_FLOAT  = 3'd3,
    UC_VALU   = 3'd4,
    UC_VPERM  = 3'd5,
    UC_CREG   = 3'd6,
    UC_BRANCH = 3'd7
  } unitClass_e;

  typedef enum logic [1:0] {
    HZ_NONE = 2'b00,
    HZ_STALL = 2'b01,
    HZ_NOOP = 2'b10
  } hazard_e;

  typedef struct packed {
    logic bump;
    logic closeNow;
    logic markCtr;
    logic illegal;
  } slotStrobes_t;

endpackage

// File: rtl/dgs_ctrl.sv
module dgs_ctrl
  import dgs_pkg::*;
(
  input  logic [2:0]   unitClass,
  input  logic         singleOnly,
  input  logic         ctrWrite,
  input  logic         commitStb,
  input  logic         advanceStb,
  input  logic         noopStb,
  output slotStrobes_t stb
);

  logic [1:0] strobeSum;

  always_comb begin
    strobeSum = {1'b0, commitStb} + {1'b0, advanceStb} + {1'b0, noopStb};
    stb = '0;
    stb.illegal = (strobeSum > 2'd1);
    if (!stb.illegal) begin
      if (commitStb && (unitClass != UC_PSEUDO)) begin
        stb.bump     = 1'b1;
        stb.closeNow = (unitClass == UC_BRANCH) || singleOnly;
        stb.markCtr  = ctrWrite;
      end else if (advanceStb || noopStb) begin
        stb.bump = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dgs_datapath.sv
module dgs_datapath
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slotStrobes_t     stb,
  output logic [CNT_W-1:0] count,
  output logic             ctrSet
);

  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(GROUP_SLOTS - 1);
  localparam logic [CNT_W-1:0] GROUP_C = CNT_W'(GROUP_SLOTS);

  logic [CNT_W-1:0] baseCount;
  logic [CNT_W-1:0] nextCount;
  logic             groupFull;

  always_comb begin
    baseCount = stb.closeNow ? LAST_C : count;
    nextCount = baseCount + 1'b1;
    groupFull = (nextCount == GROUP_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      ctrSet <= 1'b0;
    end else if (stb.bump) begin
      if (groupFull) begin
        count  <= '0;
        ctrSet <= 1'b0;
      end else begin
        count  <= nextCount;
        ctrSet <= ctrSet | stb.markCtr;
      end
    end
  end

endmodule

// File: rtl/dgs_classify.sv
module dgs_classify
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_WINDOW   = 2,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input  logic [2:0]       unitClass,
  input  logic             firstOnly,
  input  logic             singleOnly,
  input  logic             ctrBranch,
  input  logic [CNT_W-1:0] count,
  input  logic             ctrSet,
  output logic [1:0]       hazardClass
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(GROUP_SLOTS - 1);

  logic isPseudo;
  logic isPlain;
  logic isCreg;
  logic leadBlock;
  logic lastBlock;
  logic crBlock;

  always_comb begin
    isPseudo  = (unitClass == UC_PSEUDO);
    isCreg    = (unitClass == UC_CREG);
    isPlain   = !isPseudo && !isCreg && (unitClass != UC_BRANCH);
    leadBlock = (count != '0) && (firstOnly || singleOnly);
    lastBlock = isPlain && (count >= LAST_C);
  end

  generate
    if (CR_WINDOW < GROUP_SLOTS - 1) begin : g_crWindow
      localparam logic [CNT_W-1:0] CRW_C = CNT_W'(CR_WINDOW);
      assign crBlock = isCreg && (count >= CRW_C);
    end else begin : g_crLast
      assign crBlock = isCreg && (count >= LAST_C);
    end
  endgenerate

  always_comb begin
    if (isPseudo)                      hazardClass = HZ_NONE;
    else if (leadBlock)                hazardClass = HZ_STALL;
    else if (lastBlock || crBlock)     hazardClass = HZ_STALL;
    else if (ctrSet && ctrBranch)      hazardClass = HZ_NOOP;
    else                               hazardClass = HZ_NONE;
  end

endmodule

// File: rtl/dispatch_slot_checker.sv
module dispatch_slot_checker
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_WINDOW   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [2:0]                         unitClass,
  input  logic                               firstOnly,
  input  logic                               singleOnly,
  input  logic                               ctrWrite,
  input  logic                               ctrBranch,
  input  logic                               commitStb,
  input  logic                               advanceStb,
  input  logic                               noopStb,
  output logic [1:0]                         hazardClass,
  output logic [$clog2(GROUP_SLOTS+1)-1:0]   slotCount,
  output logic                               seqError
);

  localparam int CNT_W = $clog2(GROUP_SLOTS + 1);

  slotStrobes_t     stb;
  logic [CNT_W-1:0] count;
  logic             ctrSet;

  dgs_ctrl u_ctrl (
    .unitClass  (unitClass),
    .singleOnly (singleOnly),
    .ctrWrite   (ctrWrite),
    .commitStb  (commitStb),
    .advanceStb (advanceStb),
    .noopStb    (noopStb),
    .stb        (stb)
  );

  dgs_datapath #(.GROUP_SLOTS(GROUP_SLOTS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .count  (count),
    .ctrSet (ctrSet)
  );

  dgs_classify #(.GROUP_SLOTS(GROUP_SLOTS), .CR_WINDOW(CR_WINDOW)) u_cls (
    .unitClass   (unitClass),
    .firstOnly   (firstOnly),
    .singleOnly  (singleOnly),
    .ctrBranch   (ctrBranch),
    .count       (count),
    .ctrSet      (ctrSet),
    .hazardClass (hazardClass)
  );

  assign slotCount = count;
  assign seqError  = stb.illegal;

endmodule

// File: rtl/dispatch_slot_checker_sva.sv
module dispatch_slot_checker_sva #(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_WINDOW   = 2,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       unitClass,
  input logic             firstOnly,
  input logic             singleOnly,
  input logic             ctrWrite,
  input logic             ctrBranch,
  input logic             commitStb,
  input logic             advanceStb,
  input logic             noopStb,
  input logic [1:0]       hazardClass,
  input logic [CNT_W-1:0] slotCount,
  input logic             seqError
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(GROUP_SLOTS - 1);
  localparam logic [CNT_W-1:0] CRW_C  = CNT_W'(CR_WINDOW);

  logic onlyCommit;
  logic onlyAdvance;
  assign onlyCommit  = commitStb && !advanceStb && !noopStb;
  assign onlyAdvance = advanceStb && !commitStb && !noopStb;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slotCount <= LAST_C);

  p_pseudo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (onlyCommit && unitClass == 3'd0) |=> $stable(slotCount));

  p_pseudo_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unitClass == 3'd0) |-> (hazardClass == 2'b00));

  p_lead_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unitClass != 3'd0 && (firstOnly || singleOnly) && slotCount != '0)
      |-> (hazardClass == 2'b01));

  p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unitClass >= 3'd1 && unitClass <= 3'd5 && slotCount == LAST_C)
      |-> (hazardClass == 2'b01));

  p_cr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unitClass == 3'd6 && slotCount >= CRW_C) |-> (hazardClass == 2'b01));

  p_branch_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unitClass == 3'd7 && !firstOnly && !singleOnly && !ctrBranch)
      |-> (hazardClass == 2'b00));

  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (onlyCommit && (unitClass == 3'd7 || (singleOnly && unitClass != 3'd0)))
      |=> (slotCount == '0));

  p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (onlyAdvance && slotCount < LAST_C) |=> (slotCount == $past(slotCount) + 1'b1));

  p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seqError |=> $stable(slotCount));

endmodule

bind dispatch_slot_checker dispatch_slot_checker_sva #(
  .GROUP_SLOTS(GROUP_SLOTS), .CR_WINDOW(CR_WINDOW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .unitClass(unitClass), .firstOnly(firstOnly),
  .singleOnly(singleOnly), .ctrWrite(ctrWrite), .ctrBranch(ctrBranch),
  .commitStb(commitStb), .advanceStb(advanceStb), .noopStb(noopStb),
  .hazardClass(hazardClass), .slotCount(slotCount), .seqError(seqError)
);

// File: tb/dispatch_slot_checker_bench.sv
`timescale 1ns/1ps
module dispatch_slot_checker_bench;

  localparam int NV = 45;
  // vector: op[13:12] (0 none,1 commit,2 advance,3 noop), class[11:9],
  // flags[8:5] = first,single,ctrWrite,ctrBranch, hazard[4:3], count after[2:0]
  localparam logic [13:0] VEC [NV] = '{
    {2'd1,3'd1,4'b0000,2'd0,3'd1}, // R8
    {2'd1,3'd6,4'b0000,2'd0,3'd2}, // R5 below window
    {2'd0,3'd6,4'b0000,2'd1,3'd2}, // R5
    {2'd0,3'd1,4'b1000,2'd1,3'd2}, // R3
    {2'd1,3'd2,4'b0000,2'd0,3'd3},
    {2'd1,3'd3,4'b0000,2'd0,3'd4},
    {2'd0,3'd4,4'b0000,2'd1,3'd4}, // R4
    {2'd0,3'd5,4'b0000,2'd1,3'd4}, // R4
    {2'd0,3'd7,4'b0000,2'd0,3'd4}, // R6
    {2'd1,3'd7,4'b0000,2'd0,3'd0}, // R9
    {2'd1,3'd0,4'b0110,2'd0,3'd0}, // R2
    {2'd0,3'd7,4'b0001,2'd0,3'd0}, // R7 pseudo set nothing
    {2'd1,3'd1,4'b0010,2'd0,3'd1},
    {2'd0,3'd7,4'b0001,2'd2,3'd1}, // R7
    {2'd0,3'd1,4'b0100,2'd1,3'd1}, // R3
    {2'd2,3'd0,4'b0000,2'd0,3'd2}, // R10
    {2'd3,3'd0,4'b0000,2'd0,3'd3}, // R10
    {2'd0,3'd7,4'b0001,2'd2,3'd3}, // R7
    {2'd2,3'd0,4'b0000,2'd0,3'd4},
    {2'd3,3'd0,4'b0000,2'd0,3'd0}, // R10 wrap
    {2'd0,3'd7,4'b0001,2'd0,3'd0}, // R10 ctr cleared
    {2'd1,3'd5,4'b0100,2'd0,3'd0}, // R9 single
    {2'd1,3'd1,4'b1000,2'd0,3'd1}, // R3 at zero
    {2'd0,3'd6,4'b1000,2'd1,3'd1}, // R3
    {2'd1,3'd7,4'b0001,2'd0,3'd0},
    {2'd1,3'd1,4'b0010,2'd0,3'd1},
    {2'd2,3'd0,4'b0000,2'd0,3'd2},
    {2'd2,3'd0,4'b0000,2'd0,3'd3},
    {2'd1,3'd7,4'b0000,2'd0,3'd0}, // R9 mid group
    {2'd0,3'd7,4'b0001,2'd0,3'd0}, // R9 ctr cleared
    {2'd1,3'd1,4'b0010,2'd0,3'd1},
    {2'd2,3'd0,4'b0000,2'd0,3'd2},
    {2'd2,3'd0,4'b0000,2'd0,3'd3},
    {2'd2,3'd0,4'b0000,2'd0,3'd4},
    {2'd0,3'd1,4'b0001,2'd1,3'd4}, // R7 precedence
    {2'd0,3'd7,4'b0001,2'd2,3'd4}, // R7
    {2'd0,3'd6,4'b0000,2'd1,3'd4}, // R5
    {2'd2,3'd0,4'b0000,2'd0,3'd0}, // R8 clear
    {2'd1,3'd6,4'b1010,2'd0,3'd1},
    {2'd0,3'd7,4'b0001,2'd2,3'd1},
    {2'd1,3'd7,4'b0011,2'd2,3'd0}, // R9
    {2'd0,3'd7,4'b0001,2'd0,3'd0},
    {2'd1,3'd1,4'b0000,2'd0,3'd1},
    {2'd1,3'd0,4'b0100,2'd0,3'd1}, // R2 no count change
    {2'd2,3'd0,4'b0000,2'd0,3'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] unitClass = '0;
  logic       firstOnly = 1'b0, singleOnly = 1'b0, ctrWrite = 1'b0, ctrBranch = 1'b0;
  logic       commitStb = 1'b0, advanceStb = 1'b0, noopStb = 1'b0;
  logic [1:0] hazardClass;
  logic [2:0] slotCount;
  logic       seqError;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dispatch_slot_checker u_dispatch_slot_checker (
    .clk(clk), .rst_n(rst_n), .unitClass(unitClass), .firstOnly(firstOnly),
    .singleOnly(singleOnly), .ctrWrite(ctrWrite), .ctrBranch(ctrBranch),
    .commitStb(commitStb), .advanceStb(advanceStb), .noopStb(noopStb),
    .hazardClass(hazardClass), .slotCount(slotCount), .seqError(seqError)
  );

  task automatic check(input string req, input int actual, input int expected);
    applied++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic clearInputs();
    unitClass = '0; firstOnly = 0; singleOnly = 0; ctrWrite = 0; ctrBranch = 0;
    commitStb = 0; advanceStb = 0; noopStb = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    unitClass = 3'd1;
    #1;
    check("R1 count", int'(slotCount), 0);
    check("R1 error", int'(seqError), 0);
    check("R1 hazard", int'(hazardClass), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clearInputs();
      unitClass  = VEC[i][11:9];
      firstOnly  = VEC[i][8];
      singleOnly = VEC[i][7];
      ctrWrite   = VEC[i][6];
      ctrBranch  = VEC[i][5];
      commitStb  = (VEC[i][13:12] == 2'd1);
      advanceStb = (VEC[i][13:12] == 2'd2);
      noopStb    = (VEC[i][13:12] == 2'd3);
      #1;
      check($sformatf("R2-7 hazard vec %0d", i), int'(hazardClass), int'(VEC[i][4:3]));
      @(negedge clk);
      commitStb = 0; advanceStb = 0; noopStb = 0;
      #1;
      check($sformatf("R8-10 count vec %0d", i), int'(slotCount), int'(VEC[i][2:0]));
    end

    // R11: two strobes together are rejected (count is 2 here)
    @(negedge clk);
    clearInputs();
    unitClass = 3'd7; commitStb = 1; advanceStb = 1;
    #1;
    check("R11 error flag", int'(seqError), 1);
    @(negedge clk);
    clearInputs();
    #1;
    check("R11 count held", int'(slotCount), 2);
    check("R11 error clears", int'(seqError), 0);

    // R1: reset mid group
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset mid group", int'(slotCount), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule